// File: doc/BRIEF.md
# Execute-Only Flash Access Filter

This block sits on the request path between the bus initiators (the processor and the debug port) and an on-chip flash array. It makes one sector-aligned range of flash execute-only. Instruction fetches into that range are granted. Data writes into it are always refused. Data loads into it are refused unless two things hold: loads were enabled in the configuration, and a key has since been written by code running inside the range. A fetch outside the range drops that unlock again.

The filter follows the address of every granted processor fetch to learn whether secured code is running. While it is, debug halt and single-step requests are masked, and debug accesses to SRAM are refused. A refused access gets an error response. The first refusal is recorded in sticky flags.

Flash is visible at two address aliases, and both are decoded identically. Region bounds and options are captured while reset is held. Every response is combinational on the request. All state changes at the clock edge that follows.

Top module: `xom_filter`

## Requirements
- R1: A processor request with req_fetch=1 and req_dbg=0 is treated as a fetch whatever req_write says, and is always granted. This includes fetches into the secured region through either flash alias (default bases 0x0000_0000 and 0x1000_0000, 64 KiB each).
- R2: Any request with req_dbg=1 is a data access even if req_fetch=1. Debug requests into the secured region are refused on both aliases, and so are processor data writes into it.
- R3: A processor data read (req_fetch=0, req_write=0) into the secured region is granted only while the captured load-enable bit is 1 and data_unlocked is 1. Otherwise it is refused.
- R4: data_unlocked sets at the next edge only on a processor data write to the unlock address (default 0x4002_0010) whose req_wdata equals 0x0000_A5C3 while in_secure is 1. A wrong key, a debug write, or a write made while in_secure is 0 leaves it unchanged. Writes to the unlock address are granted.
- R5: A granted fetch outside the secured region clears data_unlocked and in_secure at the next edge.
- R6: dbg_halt_ok and dbg_step_ok follow dbg_halt_req and dbg_step_req while in_secure is 0, and are 0 while in_secure is 1.
- R7: While in_secure is 1, a debug request to SRAM (default 0x2000_0000, 16 KiB) is refused. While in_secure is 0 it is granted.
- R8: A refused request drives rsp_error=1 and rsp_grant=0. The first refusal after reset sets viol_flag, records its initiator in viol_dbg and its write bit in viol_write, and all three then hold until reset.
- R9: Region enable, first and last sector (1 KiB sectors, inclusive), and load enable are captured while rst_n is low. Changing the cfg inputs after reset has no effect.
- R10: in_secure takes, at the edge that ends a granted fetch, whether that fetch was inside the secured region. A request in the next cycle sees the new value.
- R11: Requests that fall outside the secured region and outside the rules above are granted. After reset, in_secure, data_unlocked and all violation flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; captures configuration |
| cfg_region_en | input | 1 | Secured region enable |
| cfg_first_sector | input | SEC_W | First secured sector |
| cfg_last_sector | input | SEC_W | Last secured sector (inclusive) |
| cfg_load_en | input | 1 | Permits unlocked data loads from the region |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_fetch | input | 1 | Request tagged as an instruction fetch |
| req_write | input | 1 | Data write |
| req_dbg | input | 1 | Initiator is the debug port |
| req_wdata | input | DATA_W | Write data |
| rsp_grant | output | 1 | Request allowed |
| rsp_error | output | 1 | Request refused (bus error) |
| dbg_halt_req | input | 1 | Debug halt request |
| dbg_step_req | input | 1 | Debug single-step request |
| dbg_halt_ok | output | 1 | Halt request passed to the core |
| dbg_step_ok | output | 1 | Step request passed to the core |
| in_secure | output | 1 | Last granted fetch was inside the region |
| data_unlocked | output | 1 | Data loads from the region unlocked |
| viol_flag | output | 1 | Sticky: a request was refused |
| viol_dbg | output | 1 | Initiator of the first refusal was debug |
| viol_write | output | 1 | First refusal was a write |

## Verification
The bench goes after the cycle in which secured state changes. A design that updated in_secure one cycle late would grant or refuse the request that follows a fetch by the old state. A design that missed the relock on leaving the region would still grant loads after returning from a call into open code.

Debug requests tagged as fetches, and accesses through the second alias, are aimed at the region. A filter that trusted the fetch tag or decoded only one alias would grant those reads.

Key writes are made with a wrong key, from the debug port, and from outside secured code. A design that accepted any of them would let data_unlocked rise. Configuration is changed after reset to expose a design that follows the live inputs.

// File: rtl/xom_pkg.sv
package xom_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/xom_addr_decode.sv
module xom_addr_decode #(
   parameter int ADDR_W      = 32,
   parameter int NUM_ALIAS   = 2,
   parameter logic [NUM_ALIAS*ADDR_W-1:0] ALIAS_BASES = {32'h1000_0000, 32'h0000_0000},
   parameter int FLASH_LOG2  = 16,
   parameter int SECTOR_LOG2 = 10,
   parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000,
   parameter int SRAM_LOG2   = 14,
   parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 32'h4002_0010,
   localparam int SEC_W      = FLASH_LOG2 - SECTOR_LOG2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              flash_hit,
   output logic [SEC_W-1:0]  sector,
   output logic              sram_hit,
   output logic              unlock_hit
);
   logic [NUM_ALIAS-1:0] alias_hit;

   for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
      localparam logic [ADDR_W-1:0] BASE = ALIAS_BASES[g*ADDR_W +: ADDR_W];
      if (BASE[FLASH_LOG2-1:0] != '0) begin : g_bad_base
         $error("flash alias base must be aligned to the flash size");
      end
      assign alias_hit[g] = (addr[ADDR_W-1:FLASH_LOG2] == BASE[ADDR_W-1:FLASH_LOG2]);
   end

   if (SRAM_BASE[SRAM_LOG2-1:0] != '0) begin : g_bad_sram
      $error("SRAM base must be aligned to the SRAM size");
   end

   assign flash_hit  = |alias_hit;
   assign sector     = addr[FLASH_LOG2-1:SECTOR_LOG2];
   assign sram_hit   = (addr[ADDR_W-1:SRAM_LOG2] == SRAM_BASE[ADDR_W-1:SRAM_LOG2]);
   assign unlock_hit = (addr == UNLOCK_ADDR);
endmodule

// File: rtl/xom_region_cfg.sv
module xom_region_cfg #(
   parameter int SEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic [SEC_W-1:0] cfg_first,
   input  logic [SEC_W-1:0] cfg_last,
   input  logic             cfg_load_en,
   input  logic             flash_hit,
   input  logic [SEC_W-1:0] sector,
   output logic             region_hit,
   output logic             load_en
);
   logic             en_q;
   logic [SEC_W-1:0] first_q;
   logic [SEC_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= cfg_en;
         first_q <= cfg_first;
         last_q  <= cfg_last;
         load_en <= cfg_load_en;
      end
   end

   assign region_hit = flash_hit && en_q && (sector >= first_q) && (sector <= last_q);

   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(first_q) && $stable(last_q) && $stable(en_q) && $stable(load_en));
endmodule

// File: rtl/xom_exec_tracker.sv
module xom_exec_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_grant,
   input  logic fetch_in_region,
   input  logic key_wr,
   output logic in_secure,
   output logic unlocked
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_secure <= 1'b0;
         unlocked  <= 1'b0;
      end else if (fetch_grant) begin
         in_secure <= fetch_in_region;
         if (!fetch_in_region) unlocked <= 1'b0;
      end else if (key_wr && in_secure) begin
         unlocked <= 1'b1;
      end
   end

   p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_grant && !fetch_in_region |=> !unlocked && !in_secure);
   p_unlock_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(in_secure) && $past(key_wr));
   p_sec_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_grant |=> in_secure == $past(fetch_in_region));
endmodule

// File: rtl/xom_policy.sv
module xom_policy
   import xom_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int KEY_W  = 16,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA5C3
) (
   input  logic              req_valid,
   input  logic              req_fetch,
   input  logic              req_write,
   input  logic              req_dbg,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              region_hit,
   input  logic              sram_hit,
   input  logic              unlock_hit,
   input  logic              in_secure,
   input  logic              unlocked,
   input  logic              load_en,
   output logic              deny,
   output logic              fetch_grant,
   output logic              key_wr,
   output logic              is_write
);
   localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(UNLOCK_KEY);

   acc_kind_e kind;

   always_comb begin
      if (req_fetch && !req_dbg) kind = ACC_FETCH;
      else if (req_write)        kind = ACC_WRITE;
      else                       kind = ACC_READ;
   end

   always_comb begin
      deny = 1'b0;
      if (region_hit) begin
         unique case (kind)
            ACC_FETCH: deny = 1'b0;
            ACC_WRITE: deny = 1'b1;
            default:   deny = req_dbg || !(load_en && unlocked);
         endcase
      end else if (sram_hit && req_dbg && in_secure) begin
         deny = 1'b1;
      end
      deny = deny && req_valid;
   end

   assign is_write    = (kind == ACC_WRITE);
   assign fetch_grant = req_valid && (kind == ACC_FETCH) && !deny;
   assign key_wr      = req_valid && is_write && !req_dbg && unlock_hit
                        && (req_wdata == KEY_WORD);
endmodule

// File: rtl/xom_filter.sv
module xom_filter #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_ALIAS   = 2,
   parameter logic [NUM_ALIAS*ADDR_W-1:0] ALIAS_BASES = {32'h1000_0000, 32'h0000_0000},
   parameter int FLASH_LOG2  = 16,
   parameter int SECTOR_LOG2 = 10,
   parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000,
   parameter int SRAM_LOG2   = 14,
   parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 32'h4002_0010,
   parameter int KEY_W       = 16,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA5C3,
   localparam int SEC_W      = FLASH_LOG2 - SECTOR_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_region_en,
   input  logic [SEC_W-1:0]  cfg_first_sector,
   input  logic [SEC_W-1:0]  cfg_last_sector,
   input  logic              cfg_load_en,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_fetch,
   input  logic              req_write,
   input  logic              req_dbg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_grant,
   output logic              rsp_error,
   input  logic              dbg_halt_req,
   input  logic              dbg_step_req,
   output logic              dbg_halt_ok,
   output logic              dbg_step_ok,
   output logic              in_secure,
   output logic              data_unlocked,
   output logic              viol_flag,
   output logic              viol_dbg,
   output logic              viol_write
);
   if (SECTOR_LOG2 >= FLASH_LOG2 || SECTOR_LOG2 < 2) begin : g_bad_sector
      $error("sector size must be at least a word and smaller than the flash");
   end
   if (KEY_W > DATA_W || NUM_ALIAS < 1) begin : g_bad_key
      $error("key wider than data bus or no flash alias");
   end

   logic             flash_hit, sram_hit, unlock_hit, region_hit, load_en;
   logic [SEC_W-1:0] sector;
   logic             deny, fetch_grant, key_wr, is_write;

   xom_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS), .ALIAS_BASES(ALIAS_BASES),
      .FLASH_LOG2(FLASH_LOG2), .SECTOR_LOG2(SECTOR_LOG2), .SRAM_BASE(SRAM_BASE),
      .SRAM_LOG2(SRAM_LOG2), .UNLOCK_ADDR(UNLOCK_ADDR)
   ) u_dec (
      .addr(req_addr), .flash_hit(flash_hit), .sector(sector),
      .sram_hit(sram_hit), .unlock_hit(unlock_hit)
   );

   xom_region_cfg #(.SEC_W(SEC_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_region_en),
      .cfg_first(cfg_first_sector), .cfg_last(cfg_last_sector),
      .cfg_load_en(cfg_load_en), .flash_hit(flash_hit), .sector(sector),
      .region_hit(region_hit), .load_en(load_en)
   );

   xom_policy #(.DATA_W(DATA_W), .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)) u_pol (
      .req_valid(req_valid), .req_fetch(req_fetch), .req_write(req_write),
      .req_dbg(req_dbg), .req_wdata(req_wdata), .region_hit(region_hit),
      .sram_hit(sram_hit), .unlock_hit(unlock_hit), .in_secure(in_secure),
      .unlocked(data_unlocked), .load_en(load_en), .deny(deny),
      .fetch_grant(fetch_grant), .key_wr(key_wr), .is_write(is_write)
   );

   xom_exec_tracker u_trk (
      .clk(clk), .rst_n(rst_n), .fetch_grant(fetch_grant),
      .fetch_in_region(region_hit), .key_wr(key_wr),
      .in_secure(in_secure), .unlocked(data_unlocked)
   );

   assign rsp_grant   = req_valid && !deny;
   assign rsp_error   = deny;
   assign dbg_halt_ok = dbg_halt_req && !in_secure;
   assign dbg_step_ok = dbg_step_req && !in_secure;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_flag  <= 1'b0;
         viol_dbg   <= 1'b0;
         viol_write <= 1'b0;
      end else if (rsp_error && !viol_flag) begin
         viol_flag  <= 1'b1;
         viol_dbg   <= req_dbg;
         viol_write <= is_write;
      end
   end

   p_fetch_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_fetch && !req_dbg |-> rsp_grant);
   p_dbg_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_dbg && region_hit |-> rsp_error && !rsp_grant);
   p_load_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_fetch && !req_write && region_hit && !data_unlocked |-> rsp_error);
   p_halt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_secure |-> !dbg_halt_ok && !dbg_step_ok);
   p_dbg_sram_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_dbg && sram_hit && in_secure |-> rsp_error);
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag |=> viol_flag && $stable(viol_dbg) && $stable(viol_write));
   p_err_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |=> viol_flag);
   p_resp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_grant && rsp_error));
endmodule

// File: tb/sim_xom_filter.sv
module sim_xom_filter;
   localparam logic [31:0] KEYW = 32'h0000_A5C3;
   localparam logic [31:0] UNL  = 32'h4002_0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_region_en = 1'b1;
   logic [5:0]  cfg_first_sector = 6'd4;
   logic [5:0]  cfg_last_sector = 6'd7;
   logic        cfg_load_en = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_fetch = 1'b0;
   logic        req_write = 1'b0;
   logic        req_dbg = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        dbg_halt_req = 1'b0;
   logic        dbg_step_req = 1'b0;
   logic        rsp_grant, rsp_error, dbg_halt_ok, dbg_step_ok;
   logic        in_secure, data_unlocked, viol_flag, viol_dbg, viol_write;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit       m_en, m_load, m_sec, m_unl, m_vf, m_vd, m_vw;
   bit [5:0] m_first, m_last;

   always #5 clk = ~clk;

   xom_filter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_region_en(cfg_region_en),
      .cfg_first_sector(cfg_first_sector), .cfg_last_sector(cfg_last_sector),
      .cfg_load_en(cfg_load_en), .req_valid(req_valid), .req_addr(req_addr),
      .req_fetch(req_fetch), .req_write(req_write), .req_dbg(req_dbg),
      .req_wdata(req_wdata), .rsp_grant(rsp_grant), .rsp_error(rsp_error),
      .dbg_halt_req(dbg_halt_req), .dbg_step_req(dbg_step_req),
      .dbg_halt_ok(dbg_halt_ok), .dbg_step_ok(dbg_step_ok),
      .in_secure(in_secure), .data_unlocked(data_unlocked),
      .viol_flag(viol_flag), .viol_dbg(viol_dbg), .viol_write(viol_write)
   );

   function automatic bit f_region(logic [31:0] a);
      bit fl = (a[31:16] == 16'h0000) || (a[31:16] == 16'h1000);
      return fl && m_en && (a[15:10] >= m_first) && (a[15:10] <= m_last);
   endfunction

   function automatic bit f_sram(logic [31:0] a);
      return a[31:14] == 18'h08000;
   endfunction

   function automatic bit f_deny(bit f, bit w, bit d, logic [31:0] a);
      bit fe = f && !d;
      if (f_region(a)) begin
         if (fe) return 1'b0;
         if (w || d) return 1'b1;
         return !(m_load && m_unl);
      end
      return f_sram(a) && d && m_sec;
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic do_req(bit v, logic [31:0] a, bit f, bit w, bit d, logic [31:0] wd,
                         bit h, bit s, string tag);
      bit dn, fe, kw;
      req_valid = v; req_addr = a; req_fetch = f; req_write = w; req_dbg = d;
      req_wdata = wd; dbg_halt_req = h; dbg_step_req = s;
      #2;
      dn = v && f_deny(f, w, d, a);
      fe = v && f && !d;
      kw = v && w && !fe && !d && (a == UNL) && (wd == KEYW);
      chk({rsp_grant, rsp_error} == {v && !dn, dn}, tag, "grant/error",
          {rsp_grant, rsp_error}, {v && !dn, dn});
      chk({dbg_halt_ok, dbg_step_ok} == {h && !m_sec, s && !m_sec}, "R6", "halt/step",
          {dbg_halt_ok, dbg_step_ok}, {h && !m_sec, s && !m_sec});
      if (dn && !m_vf) begin
         m_vf = 1'b1; m_vd = d; m_vw = w && !fe;
      end
      if (fe) begin
         m_sec = f_region(a);
         if (!m_sec) m_unl = 1'b0;
      end else if (kw && m_sec) begin
         m_unl = 1'b1;
      end
      @(posedge clk); #1;
      chk(in_secure == m_sec, "R10", "in_secure", in_secure, m_sec);
      chk(data_unlocked == m_unl, "R5", "unlocked", data_unlocked, m_unl);
      chk({viol_flag, viol_dbg, viol_write} == {m_vf, m_vd, m_vw}, "R8", "viol",
          {viol_flag, viol_dbg, viol_write}, {m_vf, m_vd, m_vw});
      @(negedge clk);
   endtask

   task automatic do_reset();
      req_valid = 1'b0; dbg_halt_req = 1'b0; dbg_step_req = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      m_en = cfg_region_en; m_first = cfg_first_sector; m_last = cfg_last_sector;
      m_load = cfg_load_en;
      m_sec = 0; m_unl = 0; m_vf = 0; m_vd = 0; m_vw = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic rand_phase(int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] a;
         bit f, w, d;
         int sel = $urandom_range(0, 5);
         case (sel)
            0: a = 32'h0000_1000 + ($urandom_range(0, 32'hFFF) & ~32'h3);
            1: a = 32'h1000_1000 + ($urandom_range(0, 32'hFFF) & ~32'h3);
            2: a = 32'h0000_0000 + ($urandom_range(0, 32'hFFF) & ~32'h3);
            3: a = 32'h2000_0000 + ($urandom_range(0, 32'h3FFF) & ~32'h3);
            4: a = UNL;
            default: a = 32'h3000_0000 + $urandom_range(0, 255);
         endcase
         f = ($urandom_range(0, 9) < 4);
         w = ($urandom_range(0, 9) < 3);
         d = ($urandom_range(0, 9) < 3);
         do_req($urandom_range(0, 7) != 0, a, f, w, d,
                $urandom_range(0, 1) ? KEYW : $urandom, $urandom_range(0, 1),
                $urandom_range(0, 1), "RND");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      do_reset();
      // R11: reset state
      chk({in_secure, data_unlocked, viol_flag, viol_dbg, viol_write} == 5'b0, "R11",
          "reset state", {in_secure, data_unlocked, viol_flag, viol_dbg, viol_write}, 5'b0);
      do_req(1, 32'h1000_1200, 1, 1, 0, 0, 0, 0, "R1");   // fetch via second alias
      do_req(0, 0, 0, 0, 0, 0, 1, 1, "R10");              // halt masked next cycle
      do_req(1, 32'h0000_1400, 0, 0, 0, 0, 0, 0, "R3");   // locked load refused
      do_req(1, UNL, 0, 1, 0, 32'h0000_A5C4, 0, 0, "R4"); // wrong key
      do_req(1, UNL, 0, 1, 1, KEYW, 0, 0, "R4");          // debug key write
      do_req(1, UNL, 0, 1, 0, KEYW, 0, 0, "R4");          // good key
      do_req(1, 32'h1000_1FFC, 0, 0, 0, 0, 0, 0, "R3");   // unlocked load
      do_req(1, 32'h1000_1400, 0, 0, 1, 0, 0, 0, "R2");   // debug read
      do_req(1, 32'h0000_1000, 1, 0, 1, 0, 0, 0, "R2");   // debug fetch-tag
      do_req(1, 32'h2000_0040, 0, 0, 1, 0, 0, 0, "R7");   // debug SRAM while secure
      do_req(1, 32'h0000_1800, 0, 1, 0, 0, 0, 0, "R2");   // CPU write to region
      do_req(1, 32'h0000_0100, 1, 0, 0, 0, 1, 0, "R5");   // leave region
      do_req(1, 32'h0000_1400, 0, 0, 0, 0, 0, 1, "R5");   // relocked
      do_req(1, 32'h2000_0040, 0, 0, 1, 0, 1, 1, "R7");   // debug SRAM open
      do_req(1, UNL, 0, 1, 0, KEYW, 0, 0, "R4");          // key outside secure
      do_req(1, 32'h0000_8000, 0, 0, 0, 0, 0, 0, "R11");
      do_req(1, 32'h3000_0004, 0, 1, 1, 0, 0, 0, "R11");
      cfg_first_sector = 6'd0; cfg_last_sector = 6'd63; cfg_load_en = 1'b0;
      do_req(1, 32'h0000_0100, 1, 0, 0, 0, 0, 0, "R9");   // live cfg ignored
      do_req(1, 32'h0000_1000, 1, 0, 0, 0, 0, 0, "R9");
      do_req(1, UNL, 0, 1, 0, KEYW, 0, 0, "R9");
      do_req(1, 32'h0000_1004, 0, 0, 0, 0, 0, 0, "R9");   // captured load_en=1 still
      rand_phase(600);
      // second configuration: loads disabled
      cfg_first_sector = 6'd4; cfg_last_sector = 6'd7; cfg_load_en = 1'b0;
      do_reset();
      do_req(1, 32'h0000_1100, 1, 0, 0, 0, 0, 0, "R1");
      do_req(1, UNL, 0, 1, 0, KEYW, 0, 0, "R4");
      do_req(1, 32'h0000_1104, 0, 0, 0, 0, 0, 0, "R3");   // refused despite unlock
      rand_phase(300);
      cfg_region_en = 1'b0;
      do_reset();
      do_req(1, 32'h0000_1104, 0, 1, 1, 0, 0, 0, "R11");  // region disabled
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule